// File: doc/BRIEF.md
# Serial audio link input-frame tag decoder

This block is the controller-side receiver for the codec-to-controller data line of a time-division audio link. A frame holds 256 bit clocks: a 16-bit tag slot and then twelve 20-bit slots, each sent most significant bit first. The block runs on a system clock that is faster than the bit clock. It finds the falling edges of the bit clock, aligns to the rising edge of the frame sync, and shifts in the frame. It then decodes the tag slot and the status slot (slot 1).

At the end of each complete frame the block updates all of its outputs in the same cycle and pulses a strobe. The outputs are a codec-ready flag, a per-slot valid vector, the echoed register index and an active-high fill mask for output slots 3 to 12. The fill mask tells the output framer which slots to send in the next outgoing frame. Slots 2 to 12 are also passed on as raw words.

Top module: `link_rx_tag_dec`

## Requirements
- R1: While rst_ni is low, every output reads zero.
- R2: sdin_i and sync_i are sampled at the first clk_i rising edge at which bclk_i is seen low after being high. The inputs are synchronous to clk_i, and each bclk_i phase lasts at least 2 clk_i cycles.
- R3: A sync rise is a sample of sync_i at 1 whose previous sample was 0. The next sample after a sync rise is frame bit 0 (tag bit 15). A frame is the 16-bit tag slot followed by slots 1 to 12 of 20 bits each, all most significant bit first. The sample at which the sync rise is seen still counts as a bit of any frame already in progress.
- R4: ready_o equals tag bit 15 of the last complete frame.
- R5: slot_valid_o equals tag bits 14 down to 3: bit 11 is slot 1 and bit 0 is slot 12. It reads zero while tag bit 15 is 0.
- R6: reg_idx_o equals slot-1 bits 18 down to 12 when tag bits 15 and 14 are both 1, and zero otherwise.
- R7: fill_req_o is the inverse of slot-1 bits 11 down to 2. Bit 9 is output slot 3 and bit 0 is slot 12, so a flag of 0 gives a fill bit of 1. The mask reads zero while tag bit 15 is 0.
- R8: The fill mask decoded from frame N is presented before bit 0 of frame N+1 is sampled. It holds until frame N+1 completes.
- R9: payload_o carries slots 2 to 12 unchanged. Slot 2 sits in bits 219:200 and slot 12 in bits 19:0. It updates on every complete frame, whether or not the codec is ready.
- R10: frame_done_o is high for exactly one clk_i cycle. That cycle is one clk_i edge after the sample of frame bit 255, and it is the only cycle in which any decoded output changes.
- R11: A frame cut short by a new sync rise before bit 255 gives no strobe and leaves the outputs unchanged. Tag bits 2:0 and slot-1 bits 19, 1 and 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Link bit clock, synchronous to clk_i |
| sync_i | input | 1 | Frame sync |
| sdin_i | input | 1 | Serial data from the codec |
| ready_o | output | 1 | Codec-ready flag |
| slot_valid_o | output | 12 | Per-slot valid flags, bit 11 = slot 1 |
| reg_idx_o | output | 7 | Echoed control register index |
| fill_req_o | output | 10 | Send-enable mask for output slots, bit 9 = slot 3 |
| payload_o | output | 220 | Raw slots 2 to 12 |
| frame_done_o | output | 1 | One-cycle strobe marking an output update |

## Verification
The bench sends back-to-back frames in which the sync rise falls on bit 255 of the previous frame. A design that gave the sync-rise sample priority over the frame bit would lose the last payload bit and never pulse the strobe. One frame has the codec not ready while its valid and request bits are set. A design that skipped the gating would leak those bits, and the valid, index and fill outputs would not read zero. Another frame is ready but tags slot 1 invalid, with a non-zero index and the reserved bits set. This catches an index that is not cleared and any decode that is shifted by one bit. A frame cut short by an early sync rise must leave every output unchanged; a design that committed partial data or strobed on it shows up on every compared clock.

// File: rtl/link_rx_pkg.sv
`timescale 1ns/1ps
package link_rx_pkg;
  localparam int unsigned TAG_W      = 16;
  localparam int unsigned SLOT_W     = 20;
  localparam int unsigned N_SLOTS    = 12;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned REQ_SLOT0  = 3;
  localparam int unsigned FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam int unsigned N_REQ      = N_SLOTS - REQ_SLOT0 + 1;
  localparam int unsigned PAY_W      = (N_SLOTS - 1) * SLOT_W;
  // slot-1 field layout: reserved msb, index, request flags, two reserved lsbs
  localparam int unsigned IDX_HI     = SLOT_W - 2;
  localparam int unsigned FLD_W      = IDX_W + N_REQ;
endpackage

// File: rtl/link_rx_sampler.sv
`timescale 1ns/1ps
module link_rx_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic sync_i,
  input  logic sdin_i,
  output logic fall_o,
  output logic sync_o,
  output logic sdin_o
);
  logic bclk_q, bclk_qq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      sync_o  <= 1'b0;
      sdin_o  <= 1'b0;
    end else begin
      bclk_q  <= bclk_i;
      bclk_qq <= bclk_q;
      sync_o  <= sync_i;
      sdin_o  <= sdin_i;
    end
  end

  assign fall_o = bclk_qq & ~bclk_q;

  // R2
  fall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/link_rx_align.sv
`timescale 1ns/1ps
module link_rx_align
  import link_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             sync_i,
  output logic             bit_vld_o,
  output logic [CNT_W-1:0] bit_idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic             sync_prev, active;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise      = fall_i & sync_i & ~sync_prev;
  assign bit_vld_o = fall_i & active;
  assign bit_idx_o = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
    end else if (fall_i) begin
      sync_prev <= sync_i;
      if (rise) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == LAST) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (active && cnt == '0));
endmodule

// File: rtl/link_rx_slot_dec.sv
`timescale 1ns/1ps
module link_rx_slot_dec
  import link_rx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_vld_i,
  input  logic [CNT_W-1:0]   bit_idx_i,
  input  logic               bit_i,
  output logic               ready_o,
  output logic [N_SLOTS-1:0] valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_REQ-1:0]   fill_o,
  output logic [PAY_W-1:0]   pay_o,
  output logic               done_o
);
  localparam int unsigned TAG_KEEP = N_SLOTS + 1;
  localparam logic [CNT_W-1:0] TAG_END   = CNT_W'(TAG_KEEP);
  localparam logic [CNT_W-1:0] FLD_FIRST = CNT_W'(TAG_W + SLOT_W - 1 - IDX_HI);
  localparam logic [CNT_W-1:0] FLD_END   = CNT_W'(TAG_W + SLOT_W - 1 - IDX_HI + FLD_W);
  localparam logic [CNT_W-1:0] S1_END    = CNT_W'(TAG_W + SLOT_W - 1);
  localparam logic [CNT_W-1:0] PAY_FIRST = CNT_W'(TAG_W + SLOT_W);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(FRAME_BITS - 1);

  logic [TAG_KEEP-1:0] tag_sr;
  logic [FLD_W-1:0]    fld_sr;
  logic [PAY_W-2:0]    pay_sr;
  logic [IDX_W-1:0]    idx_stg;
  logic [N_REQ-1:0]    req_stg;
  logic                rdy_n, s1v_n;

  assign rdy_n = tag_sr[TAG_KEEP-1];
  assign s1v_n = tag_sr[N_SLOTS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_sr  <= '0;
      fld_sr  <= '0;
      pay_sr  <= '0;
      idx_stg <= '0;
      req_stg <= '0;
      ready_o <= 1'b0;
      valid_o <= '0;
      idx_o   <= '0;
      fill_o  <= '0;
      pay_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= bit_vld_i && (bit_idx_i == LAST);
      if (bit_vld_i) begin
        if (bit_idx_i < TAG_END)
          tag_sr <= {tag_sr[TAG_KEEP-2:0], bit_i};
        if (bit_idx_i >= FLD_FIRST && bit_idx_i < FLD_END)
          fld_sr <= {fld_sr[FLD_W-2:0], bit_i};
        if (bit_idx_i >= PAY_FIRST)
          pay_sr <= {pay_sr[PAY_W-3:0], bit_i};
        // request flags latched once slot 1 is complete
        if (bit_idx_i == S1_END) begin
          idx_stg <= fld_sr[FLD_W-1 -: IDX_W];
          req_stg <= fld_sr[N_REQ-1:0];
        end
        if (bit_idx_i == LAST) begin
          ready_o <= rdy_n;
          valid_o <= rdy_n ? tag_sr[N_SLOTS-1:0] : '0;
          idx_o   <= (rdy_n && s1v_n) ? idx_stg : '0;
          fill_o  <= rdy_n ? ~req_stg : '0;
          pay_o   <= {pay_sr, bit_i};
        end
      end
    end
  end

  // R10
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && bit_idx_i == LAST) |=> done_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(fill_o) && $stable(valid_o) && $stable(idx_o) && $stable(ready_o)));
  // R5
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (valid_o == '0 && fill_o == '0 && idx_o == '0));
  // R6
  idx_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o[N_SLOTS-1] |-> idx_o == '0);
endmodule

// File: rtl/link_rx_tag_dec.sv
`timescale 1ns/1ps
module link_rx_tag_dec
  import link_rx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bclk_i,
  input  logic               sync_i,
  input  logic               sdin_i,
  output logic               ready_o,
  output logic [N_SLOTS-1:0] slot_valid_o,
  output logic [IDX_W-1:0]   reg_idx_o,
  output logic [N_REQ-1:0]   fill_req_o,
  output logic [PAY_W-1:0]   payload_o,
  output logic               frame_done_o
);
  logic             fall, sync_s, sdin_s, bit_vld;
  logic [CNT_W-1:0] bit_idx;

  link_rx_sampler u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (bclk_i),
    .sync_i (sync_i),
    .sdin_i (sdin_i),
    .fall_o (fall),
    .sync_o (sync_s),
    .sdin_o (sdin_s)
  );

  link_rx_align u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .sync_i    (sync_s),
    .bit_vld_o (bit_vld),
    .bit_idx_o (bit_idx)
  );

  link_rx_slot_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld),
    .bit_idx_i (bit_idx),
    .bit_i     (sdin_s),
    .ready_o   (ready_o),
    .valid_o   (slot_valid_o),
    .idx_o     (reg_idx_o),
    .fill_o    (fill_req_o),
    .pay_o     (payload_o),
    .done_o    (frame_done_o)
  );
endmodule

// File: tb/link_rx_tag_dec_tb.sv
`timescale 1ns/1ps
module link_rx_tag_dec_tb;
  localparam int EW = 1 + 12 + 7 + 10 + 220;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bclk = 1'b0, sync = 1'b0, sdin = 1'b0;
  logic         ready;
  logic [11:0]  valid;
  logic [6:0]   idx;
  logic [9:0]   fill;
  logic [219:0] pay;
  logic         done;

  int checks = 0;
  int errors = 0;
  logic [EW-1:0] exp_q[$];
  logic [EW-1:0] cur = '0;
  int  age = 0;
  bit  dn;

  always #5 clk = ~clk;

  link_rx_tag_dec u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .sync_i(sync), .sdin_i(sdin),
    .ready_o(ready), .slot_valid_o(valid), .reg_idx_o(idx), .fill_req_o(fill),
    .payload_o(pay), .frame_done_o(done)
  );

  task automatic chk(input bit ok, input string what, input logic [219:0] act, input logic [219:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  function automatic logic [EW-1:0] model(input logic [15:0] tag, input logic [19:0] s1, input logic [219:0] p);
    logic       r;
    logic [11:0] v;
    logic [6:0]  ix;
    logic [9:0]  f;
    r  = tag[15];
    v  = r ? tag[14:3] : 12'h0;
    ix = (r && tag[14]) ? s1[18:12] : 7'h0;
    f  = r ? ~s1[11:2] : 10'h0;
    return {r, v, ix, f, p};
  endfunction

  function automatic logic [219:0] mk_pay(input int seed);
    logic [219:0] p;
    for (int k = 0; k < 11; k++)
      p[k*20 +: 20] = 20'((seed * 7919 + k * 104729) ^ (k << (seed % 5)));
    return p;
  endfunction

  task automatic send_bit(input logic b, input logic s, input bit last, input logic [EW-1:0] ev);
    @(negedge clk); bclk = 1'b1; sdin = b; sync = s;
    @(negedge clk);
    @(negedge clk); bclk = 1'b0;
    if (last) exp_q.push_back(ev);
    @(negedge clk);
  endtask

  task automatic lead_in();
    send_bit(1'b0, 1'b0, 1'b0, '0);
    send_bit(1'b0, 1'b1, 1'b0, '0);
  endtask

  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [219:0] p, input bit nxt);
    logic [255:0]  fr;
    logic [EW-1:0] ev;
    fr = {tag, s1, p};
    ev = model(tag, s1, p);
    for (int i = 0; i < 256; i++)
      send_bit(fr[255-i], (i < 15) || (i == 255 && nxt), i == 255, ev);
  endtask

  // cycle-by-cycle comparison against the queued reference
  always @(posedge clk) begin
    #2;
    if (rst_ni) begin
      dn = 1'b0;
      if (exp_q.size() > 0) begin
        age++;
        if (age == 2) begin
          cur = exp_q.pop_front();
          age = 0;
          dn  = 1'b1;
        end
      end
      chk(done === dn, "R10 R3 frame_done", 220'(done), 220'(dn));
      chk(ready === cur[EW-1], "R4 ready", 220'(ready), 220'(cur[EW-1]));
      chk(valid === cur[EW-2 -: 12], "R5 slot_valid", 220'(valid), 220'(cur[EW-2 -: 12]));
      chk(idx === cur[EW-14 -: 7], "R6 reg_idx", 220'(idx), 220'(cur[EW-14 -: 7]));
      chk(fill === cur[EW-21 -: 10], "R7 R8 fill_req", 220'(fill), 220'(cur[EW-21 -: 10]));
      chk(pay === cur[219:0], "R9 R2 payload", pay, cur[219:0]);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [EW-1:0] hold;
    repeat (3) @(negedge clk);
    // R1
    chk({ready, valid, idx, fill, pay, done} === '0, "R1 reset state",
        220'({ready, valid, idx, fill, done}), '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    lead_in();
    send_frame(16'hFFF8, {1'b0, 7'h26, 10'b0101100011, 2'b00}, mk_pay(1), 1'b1);
    send_frame(16'h7FFF, {1'b0, 7'h55, 10'b0000000000, 2'b00}, mk_pay(2), 1'b1);
    // ready, slot 1 tagged invalid, reserved bits set
    send_frame(16'hA005, {1'b1, 7'h3C, 10'b1110001101, 2'b11}, mk_pay(3), 1'b1);
    send_frame(16'hC007, {1'b0, 7'h7F, 10'b0000000000, 2'b00}, mk_pay(4), 1'b1);
    send_frame(16'hFFF8, {1'b0, 7'h01, 10'b1111111111, 2'b00}, mk_pay(5), 1'b0);
    repeat (8) @(negedge clk);
    hold = model(16'hFFF8, {1'b0, 7'h01, 10'b1111111111, 2'b00}, mk_pay(5));
    // R7: all flags set means nothing to send
    chk(fill === 10'h000 && valid === 12'hFFF, "R7 all flags set", 220'({fill, valid}), 220'({10'h000, 12'hFFF}));

    // R11: partial frame cut by an early sync rise
    lead_in();
    for (int i = 0; i < 100; i++)
      send_bit(1'(i % 3 == 0), 1'(i < 15), 1'b0, '0);
    lead_in();
    chk({ready, valid, idx, fill, pay} === hold, "R11 partial frame ignored",
        220'({ready, valid, idx, fill}), 220'(hold[EW-1:220]));
    send_frame(16'hD558, {1'b0, 7'h12, 10'b1010101010, 2'b00}, mk_pay(6), 1'b0);
    repeat (8) @(negedge clk);
    // R3: realigned frame decodes after partial
    chk(ready === 1'b1 && idx === 7'h12 && fill === 10'b0101010101, "R3 realign after partial",
        220'({ready, idx, fill}), 220'({1'b1, 7'h12, 10'b0101010101}));
    repeat (4) send_bit(1'b1, 1'b0, 1'b0, '0);
    repeat (8) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule